// File: doc/BRIEF.md
# Fully Associative LRU Tag Tracker

This block is a small, fully associative tag store whose entries are held in a strict recency order, from the most recently used position (0) down to the least recently used position (N-1). A tag is the block address: the request address with its block-offset bits dropped. There is no set index, so any block can occupy any entry. Accesses that hit promote the entry to the head. Inserts always overwrite the entry at the tail. Invalidations push an entry to the tail, so it becomes the next victim. A separate probe port looks up an address without touching the order.

The same recency stack also models a series of smaller caches whose capacities grow by powers of two, from `MIN_BLOCKS` entries up to half of the full store. On every access the block reports a fit mask that tells which of these smaller capacities would also have hit. It keeps a saturating hit counter and a saturating miss counter for each of them, plus a total access counter. The number of modelled capacities is log2(N_ENTRIES) - log2(MIN_BLOCKS). It is zero when the store is no larger than `MIN_BLOCKS`.

Top module: `falru_tracker`

## Requirements
- R1: After reset, every entry is invalid and entry i holds recency position i. An access therefore misses, `victim_idx` is N_ENTRIES-1, and every counter reads 0. Internal state leaves reset two clock edges after `rst_n` rises.
- R2: The tag is `addr >> OFF_BITS`. Two addresses that differ only in their low `OFF_BITS` bits match the same entry.
- R3: An access reports `acc_hit` and the matching `acc_idx` in the same cycle. On a hit, the entry moves to position 0, and entries that were nearer the head move one position toward the tail. A miss leaves the order unchanged, and `acc_idx` then reads 0.
- R4: The probe port reports `prb_hit` and `prb_idx` combinationally. It never changes the recency order or any counter.
- R5: `victim_idx` always names the entry at position N_ENTRIES-1. An insert writes the new tag into that entry, marks it valid and moves it to position 0.
- R6: An invalidate clears the valid bit of entry `inv_idx` and moves that entry to position N_ENTRIES-1. Entries that were behind it move one position toward the head.
- R7: Bit i of `acc_fit` is 1 exactly when the access hits and the hit entry's position is below MIN_BLOCKS*2^i. Bit 0 is the smallest capacity. On a miss, every bit is 0.
- R8: An access adds one to the hit counter of every capacity whose fit bit is set, and one to the miss counter of every other capacity. A miss in the full store therefore counts a miss for every capacity. The access counter adds one on every access. `stat_sel` selects which capacity `stat_hits` and `stat_misses` show.
- R9: In one cycle, an access takes precedence over an insert, and an insert takes precedence over an invalidate. An operation that loses has no effect.
- R10: Every counter holds at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_addr | input | ADDR_W | Access address |
| acc_hit | output | 1 | Access matched a valid entry |
| acc_idx | output | IDX_W | Entry that matched |
| acc_fit | output | FIT_W | Capacities that would also hit |
| prb_addr | input | ADDR_W | Probe address |
| prb_hit | output | 1 | Probe matched a valid entry |
| prb_idx | output | IDX_W | Entry the probe matched |
| inv_valid | input | 1 | Invalidate request |
| inv_idx | input | IDX_W | Entry to invalidate |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Address to insert |
| victim_idx | output | IDX_W | Entry at the LRU position |
| stat_sel | input | SEL_W | Capacity whose counters are shown |
| stat_hits | output | CNT_W | Hit count of the selected capacity |
| stat_misses | output | CNT_W | Miss count of the selected capacity |
| stat_accesses | output | CNT_W | Total access count |

## Verification
The hardest situations to reach are those where an entry crosses a capacity boundary in the middle of a sequence. These happen when a hit on a deep entry pushes shallow entries outward, or when an invalidate pulls deep entries inward. They only appear once the store is full and the access pattern mixes reuse distances. The stimulus first fills every entry, then drives a long mixed sequence over a pool of blocks larger than the store. That sequence includes offset-only address variants, invalidates and cycles that raise all three request types together. A behavioural recency list in the bench predicts every output on every cycle, and the sequence is long enough to drive the narrowed counters into saturation.

// File: rtl/falru_pkg.sv
package falru_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_HEAD = 2'd1,
    STK_TAIL = 2'd2
  } stk_op_e;
endpackage

// File: rtl/falru_tag_array.sv
module falru_tag_array #(
  parameter int N_ENTRIES = 8,
  parameter int TAG_W     = 14,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic             a_hit,
  output logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic             b_hit,
  output logic [IDX_W-1:0] b_idx
);
  logic [N_ENTRIES-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [N_ENTRIES-1:0]            vld_q, vld_d;

  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (wr_en) begin
      tag_d[wr_idx] = wr_tag;
      vld_d[wr_idx] = 1'b1;
    end else if (clr_en) begin
      vld_d[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (wr_en || clr_en) begin
      tag_q <= tag_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    a_hit = 1'b0;
    a_idx = '0;
    b_hit = 1'b0;
    b_idx = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (vld_q[e] && tag_q[e] == a_tag) begin
        a_hit = 1'b1;
        a_idx = IDX_W'(e);
      end
      if (vld_q[e] && tag_q[e] == b_tag) begin
        b_hit = 1'b1;
        b_idx = IDX_W'(e);
      end
    end
  end

  AST_CLR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !vld_q[$past(clr_idx)]); // R6
endmodule

// File: rtl/falru_stack.sv
module falru_stack
  import falru_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  stk_op_e                         op,
  input  logic [IDX_W-1:0]                sel_idx,
  output logic [N_ENTRIES-1:0][IDX_W-1:0] pos_o,
  output logic [IDX_W-1:0]                victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [N_ENTRIES-1:0][IDX_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0]                sel_pos;
  logic [N_ENTRIES-1:0]            occ;

  assign sel_pos = pos_q[sel_idx];

  always_comb begin
    pos_d = pos_q;
    for (int e = 0; e < N_ENTRIES; e++) begin
      unique case (op)
        STK_HEAD: begin
          if (IDX_W'(e) == sel_idx)    pos_d[e] = '0;
          else if (pos_q[e] < sel_pos) pos_d[e] = pos_q[e] + 1'b1;
        end
        STK_TAIL: begin
          if (IDX_W'(e) == sel_idx)    pos_d[e] = LAST;
          else if (pos_q[e] > sel_pos) pos_d[e] = pos_q[e] - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENTRIES; e++) pos_q[e] <= IDX_W'(e);
    end else if (op != STK_HOLD) begin
      pos_q <= pos_d;
    end
  end

  always_comb begin
    victim_idx = '0;
    occ        = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (pos_q[e] == LAST) victim_idx = IDX_W'(e);
      occ[pos_q[e]] = 1'b1;
    end
  end

  assign pos_o = pos_q;

  AST_STACK_IS_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &occ); // R3
  AST_HEAD_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_HEAD) |=> pos_q[$past(sel_idx)] == '0); // R3
  AST_TAIL_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_TAIL) |=> victim_idx == $past(sel_idx)); // R6
endmodule

// File: rtl/falru_size_stats.sv
module falru_size_stats #(
  parameter int N_SIZES    = 2,
  parameter int MIN_BLOCKS = 2,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 32,
  localparam int FIT_W     = (N_SIZES > 0) ? N_SIZES : 1,
  localparam int SEL_W     = (N_SIZES > 1) ? $clog2(N_SIZES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_pos,
  input  logic [SEL_W-1:0] sel,
  output logic [FIT_W-1:0] fit_o,
  output logic [CNT_W-1:0] hits_o,
  output logic [CNT_W-1:0] misses_o,
  output logic [CNT_W-1:0] accesses_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (acc_q != SAT) acc_d = acc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign accesses_o = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q >= $past(acc_q)); // R10

  if (N_SIZES > 0) begin : g_sizes
    logic [N_SIZES-1:0][CNT_W-1:0] hit_q, hit_d, mis_q, mis_d;
    logic [N_SIZES-1:0]            fit;

    for (genvar i = 0; i < N_SIZES; i++) begin : g_cap
      localparam int LIM_I = MIN_BLOCKS << i;
      localparam logic [IDX_W:0] LIM = LIM_I[IDX_W:0];
      assign fit[i] = hit && ({1'b0, hit_pos} < LIM);

      always_comb begin
        hit_d[i] = hit_q[i];
        mis_d[i] = mis_q[i];
        if (fit[i]) begin
          if (hit_q[i] != SAT) hit_d[i] = hit_q[i] + 1'b1;
        end else begin
          if (mis_q[i] != SAT) mis_d[i] = mis_q[i] + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hit_q[i] <= '0;
          mis_q[i] <= '0;
        end else if (acc_en) begin
          hit_q[i] <= hit_d[i];
          mis_q[i] <= mis_d[i];
        end
      end

      AST_COUNTS_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != SAT) |-> (hit_q[i] + mis_q[i] == acc_q)); // R8

      if (i + 1 < N_SIZES) begin : g_nest
        AST_FIT_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
          fit[i] |-> fit[i+1]); // R7
      end
    end

    assign fit_o    = fit;
    assign hits_o   = (32'(sel) < N_SIZES) ? hit_q[sel] : '0;
    assign misses_o = (32'(sel) < N_SIZES) ? mis_q[sel] : '0;
  end else begin : g_nosizes
    assign fit_o    = '0;
    assign hits_o   = '0;
    assign misses_o = '0;
  end
endmodule

// File: rtl/falru_tracker.sv
module falru_tracker
  import falru_pkg::*;
#(
  parameter int N_ENTRIES  = 8,
  parameter int ADDR_W     = 16,
  parameter int OFF_BITS   = 2,
  parameter int MIN_BLOCKS = 2,
  parameter int CNT_W      = 32,
  localparam int IDX_W     = $clog2(N_ENTRIES),
  localparam int TAG_W     = ADDR_W - OFF_BITS,
  localparam int N_SIZES   = (N_ENTRIES > MIN_BLOCKS) ?
                             ($clog2(N_ENTRIES) - $clog2(MIN_BLOCKS)) : 0,
  localparam int FIT_W     = (N_SIZES > 0) ? N_SIZES : 1,
  localparam int SEL_W     = (N_SIZES > 1) ? $clog2(N_SIZES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [FIT_W-1:0]  acc_fit,
  input  logic [ADDR_W-1:0] prb_addr,
  output logic              prb_hit,
  output logic [IDX_W-1:0]  prb_idx,
  input  logic              inv_valid,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  output logic [IDX_W-1:0]  victim_idx,
  input  logic [SEL_W-1:0]  stat_sel,
  output logic [CNT_W-1:0]  stat_hits,
  output logic [CNT_W-1:0]  stat_misses,
  output logic [CNT_W-1:0]  stat_accesses
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                            do_acc, do_ins, do_inv;
  logic                            a_hit;
  logic [IDX_W-1:0]                a_idx;
  logic [N_ENTRIES-1:0][IDX_W-1:0] pos;
  stk_op_e                         stk_op;
  logic [IDX_W-1:0]                stk_sel;

  assign do_acc = acc_valid;
  assign do_ins = ins_valid && !acc_valid;
  assign do_inv = inv_valid && !acc_valid && !ins_valid;

  always_comb begin
    stk_op  = STK_HOLD;
    stk_sel = '0;
    if (do_acc && a_hit) begin
      stk_op  = STK_HEAD;
      stk_sel = a_idx;
    end else if (do_ins) begin
      stk_op  = STK_HEAD;
      stk_sel = victim_idx;
    end else if (do_inv) begin
      stk_op  = STK_TAIL;
      stk_sel = inv_idx;
    end
  end

  falru_tag_array #(.N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W)) tags_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (do_ins),
    .wr_idx  (victim_idx),
    .wr_tag  (ins_addr[ADDR_W-1:OFF_BITS]),
    .clr_en  (do_inv),
    .clr_idx (inv_idx),
    .a_tag   (acc_addr[ADDR_W-1:OFF_BITS]),
    .a_hit   (a_hit),
    .a_idx   (a_idx),
    .b_tag   (prb_addr[ADDR_W-1:OFF_BITS]),
    .b_hit   (prb_hit),
    .b_idx   (prb_idx)
  );

  falru_stack #(.N_ENTRIES(N_ENTRIES)) stack_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .op         (stk_op),
    .sel_idx    (stk_sel),
    .pos_o      (pos),
    .victim_idx (victim_idx)
  );

  falru_size_stats #(
    .N_SIZES(N_SIZES), .MIN_BLOCKS(MIN_BLOCKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) stats_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .acc_en     (do_acc),
    .hit        (a_hit),
    .hit_pos    (pos[a_idx]),
    .sel        (stat_sel),
    .fit_o      (acc_fit),
    .hits_o     (stat_hits),
    .misses_o   (stat_misses),
    .accesses_o (stat_accesses)
  );

  assign acc_hit = a_hit;
  assign acc_idx = a_idx;

  AST_MISS_NO_FIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    !a_hit |-> (acc_fit == '0)); // R7
  AST_INSERT_HITS_NEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    do_ins |=> (victim_idx != $past(victim_idx))); // R5
endmodule

// File: tb/falru_tracker_tb_top.sv
module falru_tracker_tb_top;
  localparam int N      = 8;
  localparam int AW     = 16;
  localparam int OFF    = 2;
  localparam int MINB   = 2;
  localparam int CW     = 8;
  localparam int NS     = 2;
  localparam int IW     = 3;
  localparam int SAT    = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, inv_valid = 1'b0, ins_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0, prb_addr = '0, ins_addr = '0;
  logic [IW-1:0] inv_idx = '0;
  logic [0:0]    stat_sel = '0;
  logic          acc_hit, prb_hit;
  logic [IW-1:0] acc_idx, prb_idx, victim_idx;
  logic [NS-1:0] acc_fit;
  logic [CW-1:0] stat_hits, stat_misses, stat_accesses;

  always #10 clk = ~clk;

  falru_tracker #(
    .N_ENTRIES(N), .ADDR_W(AW), .OFF_BITS(OFF), .MIN_BLOCKS(MINB), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hit(acc_hit),
    .acc_idx(acc_idx), .acc_fit(acc_fit),
    .prb_addr(prb_addr), .prb_hit(prb_hit), .prb_idx(prb_idx),
    .inv_valid(inv_valid), .inv_idx(inv_idx),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .victim_idx(victim_idx),
    .stat_sel(stat_sel), .stat_hits(stat_hits), .stat_misses(stat_misses),
    .stat_accesses(stat_accesses)
  );

  int n_chk = 0;
  int n_fail = 0;
  int m_tag[N];
  bit m_val[N];
  int m_pos[N];
  int m_hit[NS];
  int m_mis[NS];
  int m_acc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mfind(input int addr);
    int r = -1;
    for (int e = 0; e < N; e++)
      if (m_val[e] && m_tag[e] == (addr >> OFF)) r = e;
    return r;
  endfunction

  function automatic int mvictim();
    int r = 0;
    for (int e = 0; e < N; e++) if (m_pos[e] == N - 1) r = e;
    return r;
  endfunction

  function automatic void mhead(input int e);
    int p = m_pos[e];
    for (int k = 0; k < N; k++) if (m_pos[k] < p) m_pos[k]++;
    m_pos[e] = 0;
  endfunction

  function automatic void mtail(input int e);
    int p = m_pos[e];
    for (int k = 0; k < N; k++) if (m_pos[k] > p) m_pos[k]--;
    m_pos[e] = N - 1;
  endfunction

  function automatic void mreset();
    for (int e = 0; e < N; e++) begin
      m_val[e] = 1'b0; m_tag[e] = 0; m_pos[e] = e;
    end
    for (int i = 0; i < NS; i++) begin m_hit[i] = 0; m_mis[i] = 0; end
    m_acc = 0;
  endfunction

  // One cycle: drive at the falling edge, check, then advance the model at the rising edge.
  task automatic step(input bit av, input int aa, input int pa, input bit iv,
                      input int ii, input bit nv, input int na, input int sel);
    int ai, pi, vi, efit;
    acc_valid = av; acc_addr = AW'(aa); prb_addr = AW'(pa);
    inv_valid = iv; inv_idx = IW'(ii); ins_valid = nv; ins_addr = AW'(na);
    stat_sel = 1'(sel);
    #1;
    ai = mfind(aa);
    pi = mfind(pa);
    vi = mvictim();
    efit = 0;
    if (ai >= 0)
      for (int i = 0; i < NS; i++) if (m_pos[ai] < (MINB << i)) efit |= (1 << i);
    chk(acc_hit == (ai >= 0), "R3 acc_hit", int'(acc_hit), int'(ai >= 0));
    chk(int'(acc_idx) == ((ai >= 0) ? ai : 0), "R3 acc_idx", int'(acc_idx), (ai >= 0) ? ai : 0);
    chk(int'(acc_fit) == efit, "R7 acc_fit", int'(acc_fit), efit);
    chk(prb_hit == (pi >= 0), "R4 prb_hit", int'(prb_hit), int'(pi >= 0));
    if (pi >= 0) chk(int'(prb_idx) == pi, "R4 prb_idx", int'(prb_idx), pi);
    chk(int'(victim_idx) == vi, "R5 victim_idx", int'(victim_idx), vi);
    chk(int'(stat_hits) == m_hit[sel], "R8 stat_hits", int'(stat_hits), m_hit[sel]);
    chk(int'(stat_misses) == m_mis[sel], "R8 stat_misses", int'(stat_misses), m_mis[sel]);
    chk(int'(stat_accesses) == m_acc, "R8 stat_accesses", int'(stat_accesses), m_acc);
    @(posedge clk);
    if (av) begin
      for (int i = 0; i < NS; i++) begin
        if ((efit >> i) & 1) begin if (m_hit[i] < SAT) m_hit[i]++; end
        else begin if (m_mis[i] < SAT) m_mis[i]++; end
      end
      if (m_acc < SAT) m_acc++;
      if (ai >= 0) mhead(ai);
    end else if (nv) begin
      m_tag[vi] = na >> OFF; m_val[vi] = 1'b1; mhead(vi);
    end else if (iv) begin
      m_val[ii] = 1'b0; mtail(ii);
    end
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int a, r, blk;
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int'(victim_idx) == N - 1, "R1 victim after reset", int'(victim_idx), N - 1);
    chk(int'(stat_accesses) == 0, "R1 accesses after reset", int'(stat_accesses), 0);
    step(1, 'h40, 'h40, 0, 0, 0, 0, 0);            // R1 miss on empty store
    // fill all entries (R5)
    for (int k = 0; k < N; k++) step(0, 0, k * 4, 0, 0, 1, k * 4, k % 2);
    // R2: offset-only variants hit the same entry
    step(1, 4 * 3 + 1, 4 * 3 + 3, 0, 0, 0, 0, 1);
    // R3 hit on deepest entry, then shallow entry
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4 * 7 + 2, 4 * 6, 0, 0, 0, 0, 1);
    // R4: probes alone leave the order intact
    for (int k = 0; k < 4; k++) step(0, 0, k * 8, 0, 0, 0, 0, k % 2);
    // R6: invalidate entry 2, it becomes the victim
    step(0, 0, 8, 1, 2, 0, 0, 0);
    step(1, 8, 8, 0, 0, 0, 0, 0);
    // R9: access beats insert and invalidate; insert beats invalidate
    step(1, 4, 4, 1, 1, 1, 'h100, 1);
    step(0, 0, 'h104, 1, 1, 1, 'h104, 1);
    step(1, 'h104, 4, 0, 0, 0, 0, 0);
    // mixed stream over a pool larger than the store
    for (int it = 0; it < 500; it++) begin
      r   = $urandom % 10;
      blk = $urandom % 12;
      a   = blk * 4 + ($urandom % 4);
      if (r < 6) step(1, a, ($urandom % 12) * 4, 0, 0, 0, 0, it % 2);
      else if (r < 8) begin
        if (mfind(a) < 0) step(0, 0, a, 0, 0, 1, a, it % 2);
        else step(1, a, a, 0, 0, 0, 0, it % 2);
      end else if (r == 8) step(0, 0, a, 1, $urandom % N, 0, 0, it % 2);
      else step(1, a, a, 1, $urandom % N, 1, 'h200, it % 2);
    end
    // R10: the access counter has reached saturation and holds there
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk(int'(stat_accesses) == SAT, "R10 access counter saturated", int'(stat_accesses), SAT);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule